// File: doc/BRIEF.md
# Microwire EEPROM Burst Reader

This block is a host-side master that fetches a run of consecutive 16-bit words from a three-wire serial EEPROM. The host supplies a start address and a word count, then pulses `go`. For each word the block opens a separate chip-select cycle. It shifts out a start bit and the read opcode, then the word address. It clocks the returned data back in and hands the finished word to the host on a one-cycle valid strobe.

The serial clock is derived from the system clock by counting. Each serial bit slot is a low phase followed by a high phase, and three parameters set the lengths of the low phase, the high phase and the chip-select preamble. At a 250 MHz system clock, the defaults give at least 250 ns low, at least 750 ns high and at least 1 µs of preamble. The EEPROM returns a leading zero before the data. The block clocks 17 read slots and lets that zero fall off the top of its 16-bit shift register. After each word, chip select is dropped and a short clocked tail runs before the next word or the end-of-burst strobe.

Top module: `mw_burst_reader`

## Requirements
- R1: After reset, `mw_cs`, `mw_clk`, `mw_dout`, `busy`, `word_valid` and `done` are all low.
- R2: Each word begins with `PRE_CYC` cycles in which `mw_cs` is high while `mw_clk` and `mw_dout` are low, before any command bit.
- R3: After the preamble, the bits 1, 1, 0 appear on `mw_dout`, one per slot. A slot is `LO_CYC` cycles with `mw_clk` low, then `HI_CYC` cycles with `mw_clk` high. `mw_dout` holds its value for the whole slot.
- R4: The word address follows in `ADDR_W` further slots, most significant bit first.
- R5: Seventeen read slots follow with `mw_dout` low. `mw_din` is sampled in the last low cycle of each read slot. The first sample is dropped, and the other sixteen form the word, MSB first.
- R6: `word_valid` is high for exactly one cycle, the first high cycle of the 17th read slot, and `word_data` then carries the word just read.
- R7: After the last read slot, `mw_cs` goes low with `mw_clk` high for `HI_CYC` cycles. `mw_clk` then stays low for `2*LO_CYC` cycles before the next preamble.
- R8: Word n of a burst reads address (start + n) modulo 2^`ADDR_W`.
- R9: `busy` is high from the cycle after an accepted `go` through the last tail cycle. `done` is high for one cycle right after that tail, with `busy` low.
- R10: A `go` with `word_count` zero raises `done` in the next cycle, and `mw_cs` and `busy` stay low.
- R11: A `go` that arrives while `busy` is high has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start pulse, accepted only when idle |
| start_addr | input | ADDR_W | First word address of the burst |
| word_count | input | ADDR_W+1 | Number of words to read |
| mw_cs | output | 1 | EEPROM chip select |
| mw_clk | output | 1 | EEPROM serial clock |
| mw_dout | output | 1 | Serial command/address to the EEPROM |
| mw_din | input | 1 | Serial data from the EEPROM |
| busy | output | 1 | Burst in progress |
| word_valid | output | 1 | One-cycle strobe for `word_data` |
| word_data | output | DATA_W | Word just read |
| done | output | 1 | One-cycle end-of-burst strobe |

## Verification
Every output is registered, so the first preamble cycle, or the `done` of a zero-count request, appears in the cycle right after the edge that samples `go`. Each later event is at a fixed offset from that edge:
- The valid strobe comes `PRE_CYC + 25*(LO_CYC+HI_CYC) + LO_CYC` cycles into a word.
- Each word takes `PRE_CYC + 26*(LO_CYC+HI_CYC) + HI_CYC + 2*LO_CYC` cycles.
- `done` follows the last tail cycle.

The bench turns each accepted request into a queue of per-cycle expected pin states, starting in the cycle after the sampling edge. It pops one entry on every falling edge and compares it there, half a period away from the edge at which the design updates. A bus-level EEPROM model answers on `mw_din`, so capture timing and removal of the dummy bit are checked through `word_data`.

// File: rtl/mwr_pkg.sv
package mwr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_LO,
    ST_HI,
    ST_TL_HI,
    ST_TL_LO,
    ST_TL_X
  } mwr_state_e;

  localparam int CMD_SLOTS = 3;

endpackage

// File: rtl/mwr_phase_timer.sv
module mwr_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire = (cnt_q == '0);

  // R2/R3/R7: every phase starts from the length the controller asked for
  a_r2_phase_load: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/mwr_rx_shift.sv
module mwr_rx_shift #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              sample,
  input  logic              din,
  output logic [DATA_W-1:0] word,
  output logic              valid
);

  localparam int SMP_N = DATA_W + 1;
  localparam int SC_W  = $clog2(SMP_N + 1);

  logic [DATA_W-1:0] shreg_q;
  logic [SC_W-1:0]   nsmp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q <= '0;
      nsmp_q  <= '0;
      word    <= '0;
      valid   <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (clear) begin
        nsmp_q <= '0;
      end else if (sample) begin
        shreg_q <= {shreg_q[DATA_W-2:0], din};
        nsmp_q  <= nsmp_q + 1'b1;
        if (nsmp_q == SC_W'(SMP_N - 1)) begin
          word  <= {shreg_q[DATA_W-2:0], din};
          valid <= 1'b1;
        end
      end
    end
  end

  // R5: a word is only presented right after a capture
  a_r5_valid_after_sample: assert property (@(posedge clk) disable iff (rst)
    valid |-> $past(sample));

  // R5: never more captures than dummy + data bits
  a_r5_sample_bound: assert property (@(posedge clk) disable iff (rst)
    nsmp_q <= SC_W'(SMP_N));

endmodule

// File: rtl/mw_burst_reader.sv
module mw_burst_reader
  import mwr_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 16,
  parameter int HI_CYC  = 188,
  parameter int LO_CYC  = 63,
  parameter int PRE_CYC = 250
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W:0]   word_count,
  output logic              mw_cs,
  output logic              mw_clk,
  output logic              mw_dout,
  input  logic              mw_din,
  output logic              busy,
  output logic              word_valid,
  output logic [DATA_W-1:0] word_data,
  output logic              done
);

  localparam int RD_FIRST = CMD_SLOTS + ADDR_W;
  localparam int SLOTS    = RD_FIRST + DATA_W + 1;
  localparam int BIT_W    = $clog2(SLOTS);
  localparam int MAX_AB   = (HI_CYC > LO_CYC) ? HI_CYC : LO_CYC;
  localparam int MAXC     = (PRE_CYC > MAX_AB) ? PRE_CYC : MAX_AB;
  localparam int CNT_W    = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] PRE_LD = CNT_W'(PRE_CYC - 1);
  localparam logic [CNT_W-1:0] HI_LD  = CNT_W'(HI_CYC - 1);
  localparam logic [CNT_W-1:0] LO_LD  = CNT_W'(LO_CYC - 1);

  mwr_state_e        state_q, state_d;
  logic [BIT_W-1:0]  slot_q, slot_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ADDR_W:0]   left_q, left_d;
  logic              ld;
  logic [CNT_W-1:0]  ld_val;
  logic              expire;
  logic              done_d;
  logic              sample;

  // value driven on the data line in a given slot
  function automatic logic slot_value(input logic [BIT_W-1:0] b,
                                      input logic [ADDR_W-1:0] a);
    int i;
    logic [ADDR_W-1:0] sh;
    i = int'(b);
    if (i < 2) return 1'b1;
    if (i < CMD_SLOTS) return 1'b0;
    if (i < RD_FIRST) begin
      sh = a << (i - CMD_SLOTS);
      return sh[ADDR_W-1];
    end
    return 1'b0;
  endfunction

  mwr_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (ld),
    .load_val (ld_val),
    .expire   (expire)
  );

  always_comb begin
    state_d = state_q;
    slot_d  = slot_q;
    addr_d  = addr_q;
    left_d  = left_q;
    ld      = 1'b0;
    ld_val  = '0;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (go) begin
        if (word_count == '0) begin
          done_d = 1'b1;
        end else begin
          state_d = ST_PRE;
          ld = 1'b1; ld_val = PRE_LD;
          addr_d = start_addr;
          left_d = word_count;
          slot_d = '0;
        end
      end
      ST_PRE: if (expire) begin
        state_d = ST_LO; ld = 1'b1; ld_val = LO_LD; slot_d = '0;
      end
      ST_LO: if (expire) begin
        state_d = ST_HI; ld = 1'b1; ld_val = HI_LD;
      end
      ST_HI: if (expire) begin
        ld = 1'b1;
        if (slot_q == BIT_W'(SLOTS - 1)) begin
          state_d = ST_TL_HI; ld_val = HI_LD;
        end else begin
          state_d = ST_LO; ld_val = LO_LD; slot_d = slot_q + 1'b1;
        end
      end
      ST_TL_HI: if (expire) begin
        state_d = ST_TL_LO; ld = 1'b1; ld_val = LO_LD;
      end
      ST_TL_LO: if (expire) begin
        state_d = ST_TL_X; ld = 1'b1; ld_val = LO_LD;
      end
      ST_TL_X: if (expire) begin
        if (left_q == (ADDR_W+1)'(1)) begin
          state_d = ST_IDLE; done_d = 1'b1;
        end else begin
          state_d = ST_PRE; ld = 1'b1; ld_val = PRE_LD;
          addr_d = addr_q + 1'b1;
          left_d = left_q - 1'b1;
          slot_d = '0;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign sample = (state_q == ST_LO) && expire && (slot_q >= BIT_W'(RD_FIRST));

  mwr_rx_shift #(.DATA_W(DATA_W)) u_rx (
    .clk    (clk),
    .rst    (rst),
    .clear  (state_q == ST_PRE),
    .sample (sample),
    .din    (mw_din),
    .word   (word_data),
    .valid  (word_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
      addr_q  <= '0;
      left_q  <= '0;
      mw_cs   <= 1'b0;
      mw_clk  <= 1'b0;
      mw_dout <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      slot_q  <= slot_d;
      addr_q  <= addr_d;
      left_q  <= left_d;
      mw_cs   <= (state_d == ST_PRE) || (state_d == ST_LO) || (state_d == ST_HI);
      mw_clk  <= (state_d == ST_HI) || (state_d == ST_TL_HI);
      mw_dout <= ((state_d == ST_LO) || (state_d == ST_HI)) ? slot_value(slot_d, addr_d) : 1'b0;
      busy    <= (state_d != ST_IDLE);
      done    <= done_d;
    end
  end

  // R3: data line holds across a high phase
  a_r3_dout_hold_high: assert property (@(posedge clk) disable iff (rst)
    (mw_cs && mw_clk && $past(mw_clk)) |-> $stable(mw_dout));

  // R2: chip select opens with the serial clock low
  a_r2_cs_rise_clk_low: assert property (@(posedge clk) disable iff (rst)
    $rose(mw_cs) |-> !mw_clk);

  // R6: valid is a single-cycle strobe
  a_r6_valid_single: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> !word_valid);

  // R9: done only once the burst has ended
  a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R7: pins are quiet whenever no burst runs
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mw_cs && !mw_clk));

  // R10: zero-length request completes at once without selecting
  a_r10_zero_count: assert property (@(posedge clk) disable iff (rst)
    (go && !busy && word_count == '0) |=> (done && !mw_cs && !busy));

endmodule

// File: tb/test_mw_burst_reader.sv
`timescale 1ns/1ps
module test_mw_burst_reader;

  localparam int AW   = 6;
  localparam int DW   = 16;
  localparam int HI   = 3;
  localparam int LO   = 2;
  localparam int PRE  = 5;
  localparam int NSLOT = 3 + AW + DW + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          go = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [AW:0]   word_count = '0;
  logic          mw_cs, mw_clk, mw_dout;
  logic          mw_din = 1'b0;
  logic          busy, word_valid, done;
  logic [DW-1:0] word_data;

  always #2 clk = ~clk;

  mw_burst_reader #(.ADDR_W(AW), .DATA_W(DW), .HI_CYC(HI), .LO_CYC(LO), .PRE_CYC(PRE)) i_mw_burst_reader (
    .clk(clk), .rst(rst), .go(go), .start_addr(start_addr), .word_count(word_count),
    .mw_cs(mw_cs), .mw_clk(mw_clk), .mw_dout(mw_dout), .mw_din(mw_din),
    .busy(busy), .word_valid(word_valid), .word_data(word_data), .done(done)
  );

  // EEPROM content
  logic [DW-1:0] mem [2**AW];
  initial begin
    for (int i = 0; i < 2**AW; i++) mem[i] = DW'((i * 40503) ^ 23130 ^ (i << 11));
  end

  // bus-level EEPROM model, evaluated on falling edges
  int m_rx = 0;
  int m_shift = 0;
  bit m_rd = 0;
  int m_idx = 0;
  int m_addr = 0;
  logic m_sk_prev = 1'b0;
  always @(negedge clk) begin
    if (!mw_cs) begin
      m_rx = 0; m_rd = 0; m_shift = 0; mw_din = 1'b0;
    end else if (mw_clk && !m_sk_prev) begin
      if (m_rd) begin
        if (m_idx >= 0) begin
          mw_din = mem[m_addr][m_idx];
          m_idx--;
        end else mw_din = 1'b0;
      end else begin
        m_shift = (m_shift << 1) | int'(mw_dout);
        m_rx++;
        if (m_rx == 3 + AW) begin
          m_addr = m_shift & ((1 << AW) - 1);
          m_rd = 1; m_idx = DW - 1; mw_din = 1'b0;
        end
      end
    end
    m_sk_prev = mw_clk;
  end

  // expected per-cycle pins {cs,sk,dout,busy,done,valid}
  logic [5:0]    q_pins[$];
  logic [DW-1:0] q_data[$];
  string         q_tag[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit chk_on = 0;
  int cyc = 0;

  task automatic push(input logic [5:0] p, input logic [DW-1:0] d, input string t);
    q_pins.push_back(p); q_data.push_back(d); q_tag.push_back(t);
  endtask

  task automatic plan_burst(input int st, input int cnt, input string ovr);
    string t;
    for (int w = 0; w < cnt; w++) begin
      int a = (st + w) % (2**AW);
      t = (ovr != "") ? ovr : "R2";
      for (int c = 0; c < PRE; c++) push(6'b100100, '0, t);
      for (int s = 0; s < NSLOT; s++) begin
        logic v;
        if (s < 2) v = 1'b1;
        else if (s < 3) v = 1'b0;
        else if (s < 3 + AW) v = 1'((a >> (AW - 1 - (s - 3))) & 1);
        else v = 1'b0;
        if (ovr != "") t = ovr;
        else if (s < 3) t = "R3";
        else if (s < 3 + AW) t = (w > 0) ? "R8" : "R4";
        else t = "R5";
        for (int c = 0; c < LO; c++) push({1'b1, 1'b0, v, 3'b100}, '0, t);
        for (int c = 0; c < HI; c++) begin
          if (s == NSLOT - 1 && c == 0)
            push({1'b1, 1'b1, v, 3'b101}, mem[a], (ovr != "") ? ovr : ((w > 0) ? "R8" : "R6"));
          else
            push({1'b1, 1'b1, v, 3'b100}, '0, t);
        end
      end
      t = (ovr != "") ? ovr : "R7";
      for (int c = 0; c < HI; c++) push(6'b010100, '0, t);
      for (int c = 0; c < 2 * LO; c++) push(6'b000100, '0, t);
    end
    push(6'b000010, '0, (ovr != "") ? ovr : "R9");
  endtask

  // per-cycle comparison on falling edges
  always @(negedge clk) begin
    if (chk_on) begin
      logic [5:0] act, exp_p;
      logic [DW-1:0] exp_d;
      string t;
      cyc++;
      act = {mw_cs, mw_clk, mw_dout, busy, done, word_valid};
      if (q_pins.size() != 0) begin
        exp_p = q_pins.pop_front(); exp_d = q_data.pop_front(); t = q_tag.pop_front();
      end else begin
        exp_p = 6'b0; exp_d = '0; t = "R9";
      end
      n_cmp++;
      if (act !== exp_p) begin
        n_bad++;
        $display("FAIL %s cycle %0d pins{cs,sk,do,busy,done,vld} act %b exp %b", t, cyc, act, exp_p);
      end else if (exp_p[0] && word_data !== exp_d) begin
        n_bad++;
        $display("FAIL %s cycle %0d word_data act %h exp %h", t, cyc, word_data, exp_d);
      end
    end
  end

  task automatic issue(input int st, input int cnt, input bit accept, input string ovr);
    @(negedge clk); #1;
    go = 1'b1; start_addr = AW'(st); word_count = (AW+1)'(cnt);
    if (accept) plan_burst(st, cnt, ovr);
    @(negedge clk); #1;
    go = 1'b0;
  endtask

  task automatic drain();
    while (q_pins.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    n_cmp++;
    if ({mw_cs, mw_clk, mw_dout, busy, done, word_valid} !== 6'b0) begin
      n_bad++;
      $display("FAIL R1 reset pins act %b exp %b", {mw_cs, mw_clk, mw_dout, busy, done, word_valid}, 6'b0);
    end
    #1 rst = 1'b0;
    chk_on = 1;
    repeat (3) @(negedge clk);

    issue(5, 3, 1, "");          // R2..R9 basic burst
    drain();
    issue(62, 3, 1, "");         // R8 wrap 62,63,0
    drain();
    issue(0, 0, 1, "R10");       // R10 zero count
    drain();
    issue(33, 1, 1, "");         // single word, different address pattern
    drain();
    issue(10, 2, 1, "R11");      // R11: second go during the burst is ignored
    repeat (40) @(negedge clk);
    issue(40, 5, 0, "R11");
    repeat (100) @(negedge clk);
    issue(41, 0, 0, "R11");
    drain();
    issue(63, 1, 1, "");         // top address
    drain();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R9 watchdog: act no end of test, exp finish before timeout");
    finish_run();
  end

endmodule